// File: doc/BRIEF.md
# External 16-bit Bus Access Sizer

This block connects an internal access port to a 16-bit external data bus. The internal side presents one request at a time: an address, a transfer size (byte, word or longword), a direction flag and up to 32 bits of write data. The block turns that request into one or two external bus cycles. It steers each byte onto the proper half of the bus and drives an active-low read strobe and two active-low write strobes, one for each data half.

A byte travels on the upper lines when its address is even and on the lower lines when its address is odd. A word uses the full bus in a single cycle. A longword is split into two cycles in big-endian order. For reads, the sampled bus data is gathered into a right-aligned 32-bit result, which is presented together with a one-clock completion pulse. A word or longword request at an odd address is rejected with an alignment-error pulse, and no bus activity takes place.

Top module: `ext_bus_sizer`

## Requirements
- R1: A byte access at an even address uses lines 15..8. On a write, the data byte (write-data bits 7..0) goes on lines 15..8, lines 7..0 are driven zero, and only `hwr_n` is asserted. On a read, `rdata` returns bus bits 15..8.
- R2: A byte access at an odd address uses lines 7..0. On a write, the data byte goes on lines 7..0, lines 15..8 are driven zero, and only `lwr_n` is asserted. On a read, `rdata` returns bus bits 7..0.
- R3: For every read, whatever its size, `rd_n` is asserted in each bus cycle and neither write strobe is asserted. For every write, `rd_n` stays high.
- R4: A word access (`req_size` = 1) takes exactly one bus cycle. A word write drives write-data bits 15..0 and asserts both `hwr_n` and `lwr_n`. A word read returns the bus value in `rdata` bits 15..0.
- R5: A longword access (`req_size` = 2, with code 3 treated the same way) takes two bus cycles. The first cycle carries bits 31..16 at the request address. The second carries bits 15..0 at the request address plus 2. A longword read returns {first, second}.
- R6: A word or longword request whose address bit 0 is set produces a one-clock `align_err` pulse in the cycle after the request is presented. In that case no strobe is asserted, `busy` stays low and no `done` pulse is produced.
- R7: All strobes are active low and are high whenever `busy` is low.
- R8: Each bus cycle lasts two clocks. In the first clock the address and write data are valid and all strobes are high. In the second clock the strobes are asserted, and the address and data stay unchanged.
- R9: A byte read returns the sampled byte zero-extended: `rdata` bits 31..8 are zero.
- R10: An accepted request raises `busy` on the next clock, and `busy` stays high until the final bus cycle ends. `done` then pulses for one clock, with `busy` low during the pulse. A request presented while `busy` is high is ignored.
- R11: While reset is held, `busy`, `done` and `align_err` are low, all strobes are high and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| align_err | output | 1 | One-clock pulse for a rejected odd word/longword request |
| rdata | output | 32 | Right-aligned read result, valid with `done` |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | 16 | External write data |
| bus_din | input | 16 | External read data, sampled at the end of the strobe clock |
| rd_n | output | 1 | Read strobe, active low |
| hwr_n | output | 1 | Upper-half write strobe, active low |
| lwr_n | output | 1 | Lower-half write strobe, active low |

## Verification
The assertions assume that `bus_din` is stable around the clock edge that ends the strobe state. They also assume that a request is judged only while `busy` is low, so the properties tie alignment rejection to that condition alone. The stimulus changes every input half a clock away from the active edge. It loads `bus_din` during the address clock of each bus cycle and holds it through the strobe clock. It drops `req_valid` once the request has been taken, except in the scenario that deliberately holds a conflicting request during a busy transfer.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    localparam int BUS_W  = 16;
    localparam int HALF_W = BUS_W / 2;
    localparam int ACC_W  = 2 * BUS_W;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONG3 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2
    } phase_e;

    // Latched request fields other than the address
    typedef struct packed {
        size_e              size;
        logic               write;
        logic [ACC_W-1:0]   wdata;
    } req_t;

    // One bus cycle's worth of outgoing lane information
    typedef struct packed {
        logic [BUS_W-1:0]   data;
        logic               up_en;
        logic               lo_en;
    } lane_t;

    function automatic logic is_misaligned(size_e s, logic lsb);
        return (s != SZ_BYTE) && lsb;
    endfunction

    function automatic logic needs_two_beats(size_e s);
        return (s == SZ_LONG) || (s == SZ_LONG3);
    endfunction

endpackage

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer
    import bsz_pkg::*;
(
    input  size_e              size,
    input  logic               lsb,
    input  logic               beat,
    input  logic [ACC_W-1:0]   wdata,
    output lane_t              lane
);

    always_comb begin
        lane = '0;
        unique case (size)
            SZ_BYTE: begin
                if (lsb) begin
                    lane.data[HALF_W-1:0] = wdata[HALF_W-1:0];
                    lane.lo_en            = 1'b1;
                end else begin
                    lane.data[BUS_W-1:HALF_W] = wdata[HALF_W-1:0];
                    lane.up_en                = 1'b1;
                end
            end
            SZ_WORD: begin
                lane.data  = wdata[BUS_W-1:0];
                lane.up_en = 1'b1;
                lane.lo_en = 1'b1;
            end
            default: begin
                lane.data  = beat ? wdata[BUS_W-1:0] : wdata[ACC_W-1:BUS_W];
                lane.up_en = 1'b1;
                lane.lo_en = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bsz_read_merge.sv
module bsz_read_merge
    import bsz_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  size_e              size,
    input  logic               lsb,
    input  logic               beat,
    input  logic [BUS_W-1:0]   din,
    output logic [ACC_W-1:0]   rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            unique case (size)
                SZ_BYTE: rdata <= {{(ACC_W-HALF_W){1'b0}},
                                   (lsb ? din[HALF_W-1:0] : din[BUS_W-1:HALF_W])};
                SZ_WORD: rdata <= {{(ACC_W-BUS_W){1'b0}}, din};
                default: begin
                    if (beat) rdata[BUS_W-1:0] <= din;
                    else      rdata            <= {din, {BUS_W{1'b0}}};
                end
            endcase
        end
    end

endmodule

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
    import bsz_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  size_e   req_size,
    input  logic    req_lsb,
    input  logic    two_beats,
    output phase_e  phase,
    output logic    beat,
    output logic    busy,
    output logic    done,
    output logic    align_err,
    output logic    start
);

    logic take;

    assign take  = req_valid && (phase == PH_IDLE);
    assign start = take && !is_misaligned(req_size, req_lsb);
    assign busy  = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            beat      <= 1'b0;
            done      <= 1'b0;
            align_err <= 1'b0;
        end else begin
            done      <= 1'b0;
            align_err <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_ADDR;
                        beat  <= 1'b0;
                    end else if (take) begin
                        align_err <= 1'b1;
                    end
                end
                PH_ADDR: phase <= PH_STRB;
                PH_STRB: begin
                    if (two_beats && !beat) begin
                        beat  <= 1'b1;
                        phase <= PH_ADDR;
                    end else begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [31:0]        req_wdata,
    output logic               busy,
    output logic               done,
    output logic               align_err,
    output logic [31:0]        rdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [15:0]        bus_dout,
    input  logic [15:0]        bus_din,
    output logic               rd_n,
    output logic               hwr_n,
    output logic               lwr_n
);

    phase_e             phase;
    logic               beat;
    logic               start;
    logic               strobe_state;
    logic               capture;
    req_t               req_q;
    logic [ADDR_W-1:0]  addr_q;
    lane_t              lane;
    size_e              in_size;

    assign in_size = size_e'(req_size);

    bsz_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_size  (in_size),
        .req_lsb   (req_addr[0]),
        .two_beats (needs_two_beats(req_q.size)),
        .phase     (phase),
        .beat      (beat),
        .busy      (busy),
        .done      (done),
        .align_err (align_err),
        .start     (start)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            addr_q <= '0;
        end else if (start) begin
            req_q.size  <= in_size;
            req_q.write <= req_write;
            req_q.wdata <= req_wdata;
            addr_q      <= req_addr;
        end
    end

    bsz_lane_steer u_lane (
        .size  (req_q.size),
        .lsb   (addr_q[0]),
        .beat  (beat),
        .wdata (req_q.wdata),
        .lane  (lane)
    );

    assign strobe_state = (phase == PH_STRB);
    assign capture      = strobe_state && !req_q.write;

    assign bus_addr = addr_q + {{(ADDR_W-2){1'b0}}, beat, 1'b0};
    assign bus_dout = lane.data;
    assign rd_n     = !(strobe_state && !req_q.write);
    assign hwr_n    = !(strobe_state && req_q.write && lane.up_en);
    assign lwr_n    = !(strobe_state && req_q.write && lane.lo_en);

    bsz_read_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .size    (req_q.size),
        .lsb     (addr_q[0]),
        .beat    (beat),
        .din     (bus_din),
        .rdata   (rdata)
    );

endmodule

// File: rtl/bsz_checker.sv
module bsz_checker #(
    parameter int ADDR_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [1:0]         req_size,
    input logic               busy,
    input logic               done,
    input logic               align_err,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [15:0]        bus_dout,
    input logic               rd_n,
    input logic               hwr_n,
    input logic               lwr_n
);

    assert_idle_strobes_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_n && hwr_n && lwr_n));

    assert_read_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (hwr_n && lwr_n));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    assert_misalign_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_size != 2'd0) && req_addr[0])
        |=> (align_err && !busy));

    assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
        align_err |=> !align_err);

    assert_strobe_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !hwr_n || !lwr_n) |-> ($stable(bus_addr) && $stable(bus_dout)));

    assert_read_one_state_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> rd_n);

    assert_write_one_state_R8: assert property (@(posedge clk) disable iff (rst)
        (!hwr_n || !lwr_n) |=> (hwr_n && lwr_n));

endmodule

bind ext_bus_sizer bsz_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .busy      (busy),
    .done      (done),
    .align_err (align_err),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rd_n      (rd_n),
    .hwr_n     (hwr_n),
    .lwr_n     (lwr_n)
);

// File: tb/sim_ext_bus_sizer.sv
module sim_ext_bus_sizer;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          busy, done, align_err;
    logic [31:0]   rdata;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din = '0;
    logic          rd_n, hwr_n, lwr_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ext_bus_sizer #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .align_err(align_err), .rdata(rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .rd_n(rd_n), .hwr_n(hwr_n), .lwr_n(lwr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Full transfer with cycle-by-cycle checks against the requirements
    task automatic xfer(input logic [AW-1:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input logic [15:0] din0, input logic [15:0] din1);
        int beats = (sz >= 2) ? 2 : 1;
        logic [15:0] exp_d;
        logic [2:0]  exp_s;
        logic [31:0] exp_r;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        for (int b = 0; b < beats; b++) begin
            if (sz == 0) exp_d = a[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
            else if (sz == 1) exp_d = wd[15:0];
            else exp_d = (b == 0) ? wd[31:16] : wd[15:0];
            if (!wr) exp_s = 3'b011;
            else if (sz == 0) exp_s = a[0] ? 3'b110 : 3'b101;
            else exp_s = 3'b100;
            // address state
            chk("R10 busy in address state", {31'b0, busy}, 32'd1);
            chk("R8 strobes idle in address state", {29'b0, rd_n, hwr_n, lwr_n}, 32'd7);
            chk("R5 bus address", {8'b0, bus_addr}, {8'b0, a + AW'(2*b)});
            if (wr) chk(sz == 0 ? (a[0] ? "R2 write lane" : "R1 write lane") :
                        (sz == 1 ? "R4 write data" : "R5 write data"),
                        {16'b0, bus_dout}, {16'b0, exp_d});
            bus_din = (b == 0) ? din0 : din1;
            @(negedge clk);
            // strobe state
            chk(wr ? (sz == 0 ? (a[0] ? "R2 strobes" : "R1 strobes") : "R4 strobes")
                   : "R3 read strobes",
                {29'b0, rd_n, hwr_n, lwr_n}, {29'b0, exp_s});
            chk("R8 address held in strobe state", {8'b0, bus_addr}, {8'b0, a + AW'(2*b)});
            if (wr) chk("R8 data held in strobe state", {16'b0, bus_dout}, {16'b0, exp_d});
            @(negedge clk);
        end
        chk("R10 done pulse", {31'b0, done}, 32'd1);
        chk("R10 busy low at done", {31'b0, busy}, 32'd0);
        chk("R7 strobes high after transfer", {29'b0, rd_n, hwr_n, lwr_n}, 32'd7);
        if (!wr) begin
            if (sz == 0) exp_r = {24'b0, a[0] ? din0[7:0] : din0[15:8]};
            else if (sz == 1) exp_r = {16'b0, din0};
            else exp_r = {din0, din1};
            chk(sz == 0 ? "R9 byte read zero-extended" : (sz == 1 ? "R4 word read" : "R5 long read"),
                rdata, exp_r);
        end
        @(negedge clk);
        chk("R10 done single clock", {31'b0, done}, 32'd0);
    endtask

    task automatic misaligned(input logic [AW-1:0] a, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz; req_write = 1; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 0;
        chk("R6 align_err pulse", {31'b0, align_err}, 32'd1);
        chk("R6 busy stays low", {31'b0, busy}, 32'd0);
        chk("R6 no strobes", {29'b0, rd_n, hwr_n, lwr_n}, 32'd7);
        @(negedge clk);
        chk("R6 align_err single", {31'b0, align_err}, 32'd0);
        chk("R6 no done", {31'b0, done}, 32'd0);
        chk("R6 still idle", {31'b0, busy}, 32'd0);
    endtask

    // Conflicting request held while busy must not alter the transfer
    task automatic ignore_busy();
        @(negedge clk);
        req_valid = 1; req_addr = 24'h000100; req_size = 2'd1; req_write = 1; req_wdata = 32'h0000_1234;
        @(negedge clk);
        req_addr = 24'h000203; req_size = 2'd0; req_wdata = 32'h0000_00EE;
        chk("R10 busy after accept", {31'b0, busy}, 32'd1);
        @(negedge clk);
        chk("R10 ignored request: address", {8'b0, bus_addr}, 32'h000100);
        chk("R10 ignored request: data", {16'b0, bus_dout}, 32'h1234);
        chk("R10 ignored request: strobes", {29'b0, rd_n, hwr_n, lwr_n}, 32'b100);
        req_valid = 0;
        @(negedge clk);
        chk("R10 done after word", {31'b0, done}, 32'd1);
        @(negedge clk);
        chk("R10 no second transfer", {31'b0, busy}, 32'd0);
        chk("R7 strobes high when idle", {29'b0, rd_n, hwr_n, lwr_n}, 32'd7);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R11 busy in reset", {31'b0, busy}, 32'd0);
        chk("R11 done in reset", {31'b0, done}, 32'd0);
        chk("R11 align_err in reset", {31'b0, align_err}, 32'd0);
        chk("R11 strobes in reset", {29'b0, rd_n, hwr_n, lwr_n}, 32'd7);
        chk("R11 rdata in reset", rdata, 32'd0);
        rst = 0;
        @(negedge clk);
        xfer(24'h000010, 2'd0, 1'b1, 32'hFFFF_FFA5, 16'h0, 16'h0);   // R1
        xfer(24'h000011, 2'd0, 1'b1, 32'h0000_003C, 16'h0, 16'h0);   // R2
        xfer(24'h000020, 2'd0, 1'b0, 32'h0, 16'hB7C4, 16'h0);        // R1 R9
        xfer(24'h000021, 2'd0, 1'b0, 32'h0, 16'hB7C4, 16'h0);        // R2 R9
        xfer(24'h000030, 2'd1, 1'b1, 32'hAAAA_5A69, 16'h0, 16'h0);   // R4
        xfer(24'h000032, 2'd1, 1'b0, 32'h0, 16'h8001, 16'h0);        // R4 R3
        xfer(24'h000040, 2'd2, 1'b1, 32'h1122_3344, 16'h0, 16'h0);   // R5
        xfer(24'h00FFFE, 2'd2, 1'b0, 32'h0, 16'hCAFE, 16'hF00D);     // R5 R3
        xfer(24'h000050, 2'd3, 1'b1, 32'h9876_5432, 16'h0, 16'h0);   // R5 code 3
        misaligned(24'h000061, 2'd1);                                 // R6 word
        misaligned(24'h000063, 2'd2);                                 // R6 long
        ignore_busy();                                                // R10
        xfer(24'h000071, 2'd0, 1'b0, 32'h0, 16'h1F2E, 16'h0);        // after ignore
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule